// File: doc/BRIEF.md
# Sliced Binary-Field Half-Trace Solver and Trace Unit

This unit sits next to a 32-bit processor core and helps with normal-basis arithmetic over GF(2^163). It computes two functions. The first solves X^2 + X = A. The second computes the trace of A. The core cannot pass a 163-bit value in one call. Every function is therefore driven as a series of calls, each with two 32-bit operands, a small word index and a function select. Each call returns a 32-bit result in the same cycle.

Element bit a_i lives in word i/32, at bit position 31 - (i mod 32). Word 0 therefore starts with a0 in its most significant bit. The last word carries a160..a162 in bits 31..29, and its lower 29 bits are padding.

The solver walks the bits in order and keeps a running xor: x0 = a0, each later x_i = a_i xor x_(i-1), and x162 is forced to 0. One register bit carries the running value from one call to the next. The trace function xors all 163 bits. It consumes two words per call, so the final parity appears on the third call. The same register bit holds the partial parity between calls. The unit does not check whether a solution exists. When Tr(A) = 1, the returned X misses A in the top bit only.

Top module: `qe_trace_slicer`

## Requirements
- R1: In solve mode (call_trace = 0) with word_num k in 0..4, result bit j equals x_i for i = 32k + 31 - j. Here x0 = a0 and x_i = a_i xor x_(i-1), where a_i is read from opa at the same bit position.
- R2: A solve call with word_num k in 1..5 continues the running xor from the last bit (x at result bit 0) returned by the most recent solve call that updated the carry.
- R3: A call with word_num 0, in either mode, starts from a carry of 0, whatever earlier calls left behind.
- R4: A solve call with word_num 5 returns x160 and x161 in bits 31..30. Bit 29 (x162) and bits 28..0 are 0, and opa bits 28..0 have no effect. After this call the carry is 0.
- R5: In solve mode, opb has no effect on the result or on the carry.
- R6: A trace call (call_trace = 1) with word_num k in 0..2 xors the carry with every valid bit of opa (word 2k) and opb (word 2k+1). It returns that partial parity in bit 0, with bits 31..1 at 0, and keeps the parity as the new carry. On the call with word_num 2 the returned bit equals Tr(A).
- R7: On the trace call with word_num 2, opb bits 28..0 (padding of word 5) have no effect.
- R8: A solve call with word_num 6 or 7, or a trace call with word_num 3..7, returns 0 and leaves the carry unchanged.
- R9: While call_valid is low, result is 0 and the carry is held, so gaps between calls are allowed.
- R10: After reset the carry is 0, so a first solve call with word_num 1 behaves as if the previous call ended with x = 0.
- R11: For any A with Tr(A) = 0, the six slices form an X with X^2 + X = A, where squaring is a rotation of (x0..x162) by one place towards higher index. X + 1 (all 163 bits inverted) also satisfies this. For Tr(A) = 1, X^2 + X differs from A in bit 162 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_valid | input | 1 | A call is presented this cycle |
| call_trace | input | 1 | 1 selects trace, 0 selects the equation solver |
| word_num | input | 3 | Slice index of the call |
| opa | input | 32 | First operand word |
| opb | input | 32 | Second operand word (used by trace only) |
| result | output | 32 | Combinational result of the current call |

## Verification
The only internal state is the one carry bit. A wrong value shows up at once, on the very next call that reads it: the most significant bit of the next solve slice flips, and every later bit of that slice flips with it. A bad carry in trace mode shows as a flipped bit 0 on the next trace call, and therefore a wrong final trace. The bench checks every slice against a model of the requirements. It also rebuilds whole solutions and checks the field equation, so a carry error that survives to the end of an element still breaks X^2 + X = A.

// File: rtl/qe_trace_slicer.sv
module qe_trace_slicer #(
  parameter int W   = 32,
  parameter int M   = 163,
  parameter int WNW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           call_valid,
  input  logic           call_trace,
  input  logic [WNW-1:0] word_num,
  input  logic [W-1:0]   opa,
  input  logic [W-1:0]   opb,
  output logic [W-1:0]   result
);
  localparam int NW     = (M + W - 1) / W;
  localparam int LASTW  = NW - 1;
  localparam int TAIL   = NW * W - M;
  localparam int TCALLS = (NW + 1) / 2;
  localparam logic [W-1:0] VMASK = {W{1'b1}} << TAIL;
  localparam logic [W-1:0] XMASK = {W{1'b1}} << (TAIL + 1);

  logic           carry_q;
  logic           cin, is_last, solve_ok, trace_ok, tpar;
  logic [W-1:0]   a_eff, pfx, ta, tb;
  logic [WNW:0]   ia, ib;

  function automatic logic [W-1:0] word_sel(input logic [WNW:0] idx, input logic [W-1:0] w);
    if (idx > (WNW+1)'(LASTW))  return '0;
    if (idx == (WNW+1)'(LASTW)) return w & VMASK;
    return w;
  endfunction

  assign cin      = (word_num == '0) ? 1'b0 : carry_q;
  assign is_last  = (word_num == WNW'(LASTW));
  assign solve_ok = !call_trace && (word_num <= WNW'(LASTW));
  assign trace_ok = call_trace && (word_num < WNW'(TCALLS));
  assign a_eff    = is_last ? (opa & VMASK) : opa;

  always_comb begin
    logic c;
    c = cin;
    for (int j = W - 1; j >= 0; j--) begin
      c      = c ^ a_eff[j];
      pfx[j] = c;
    end
  end

  assign ia   = {word_num, 1'b0};
  assign ib   = {word_num, 1'b1};
  assign ta   = word_sel(ia, opa);
  assign tb   = word_sel(ib, opb);
  assign tpar = cin ^ (^ta) ^ (^tb);

  always_comb begin
    result = '0;
    if (call_valid) begin
      if (solve_ok)      result = is_last ? (pfx & XMASK) : pfx;
      else if (trace_ok) result = {{(W-1){1'b0}}, tpar};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else if (call_valid) begin
      if (solve_ok)      carry_q <= is_last ? 1'b0 : pfx[0];
      else if (trace_ok) carry_q <= tpar;
    end
  end
endmodule

// File: rtl/qe_trace_slicer_chk.sv
module qe_trace_slicer_chk #(
  parameter int W   = 32,
  parameter int M   = 163,
  parameter int WNW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           call_valid,
  input logic           call_trace,
  input logic [WNW-1:0] word_num,
  input logic [W-1:0]   opa,
  input logic [W-1:0]   result,
  input logic           carry_q
);
  localparam int NW     = (M + W - 1) / W;
  localparam int LASTW  = NW - 1;
  localparam int TAIL   = NW * W - M;
  localparam int TCALLS = (NW + 1) / 2;

  logic solve_call, trace_call, off_range;
  assign solve_call = call_valid && !call_trace;
  assign trace_call = call_valid && call_trace;
  assign off_range  = (solve_call && word_num > WNW'(LASTW)) ||
                      (trace_call && word_num >= WNW'(TCALLS));

  a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !call_valid |-> result == '0);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !call_valid |=> $stable(carry_q));

  a_r6_trace_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    trace_call |-> result[W-1:1] == '0);

  a_r4_last_tail_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (solve_call && word_num == WNW'(LASTW)) |-> result[TAIL:0] == '0);

  a_r1_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (solve_call && word_num < WNW'(LASTW)) |->
      (result[W-2:0] ^ result[W-1:1]) == opa[W-2:0]);

  a_r3_word0_start: assert property (@(posedge clk) disable iff (!rst_n)
    (solve_call && word_num == '0) |-> result[W-1] == opa[W-1]);

  a_r2_link: assert property (@(posedge clk) disable iff (!rst_n)
    (solve_call && word_num != '0 && word_num <= WNW'(LASTW) &&
     $past(solve_call) && ($past(word_num) + WNW'(1)) == word_num) |->
      result[W-1] == (opa[W-1] ^ $past(result[0])));

  a_r8_off_range_zero: assert property (@(posedge clk) disable iff (!rst_n)
    off_range |-> result == '0);

  a_r8_off_range_hold: assert property (@(posedge clk) disable iff (!rst_n)
    off_range |=> $stable(carry_q));
endmodule

bind qe_trace_slicer qe_trace_slicer_chk #(.W(W), .M(M), .WNW(WNW)) u_chk (
  .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .call_trace(call_trace),
  .word_num(word_num), .opa(opa), .result(result), .carry_q(carry_q)
);

// File: tb/qe_trace_slicer_tb.sv
module qe_trace_slicer_tb;
  logic        clk = 1'b0;
  logic        rst_n, call_valid, call_trace;
  logic [2:0]  word_num;
  logic [31:0] opa, opb, result;

  always #2 clk = ~clk;

  qe_trace_slicer u_dut (
    .clk(clk), .rst_n(rst_n), .call_valid(call_valid), .call_trace(call_trace),
    .word_num(word_num), .opa(opa), .opb(opb), .result(result)
  );

  typedef struct { logic [31:0] exp; string req; int wn; bit keep; } item_t;
  typedef logic [162:0] elem_t;

  item_t       q[$];
  int          nchk = 0, nbad = 0;
  bit          done = 0;
  bit          tb_c = 0;
  logic [31:0] got [0:5];

  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      nchk++;
      if (result !== it.exp) begin
        nbad++;
        $display("FAIL %s word=%0d actual=%h expected=%h", it.req, it.wn, result, it.exp);
      end
      if (it.keep && it.wn < 6) got[it.wn] = result;
    end
  end

  task automatic check_el(string req, string what, elem_t act, elem_t exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] word_of(elem_t e, int k);
    logic [31:0] w;
    for (int j = 0; j < 32; j++) begin
      int i;
      i = 32 * k + 31 - j;
      w[j] = (i < 163) ? e[i] : 1'b0;
    end
    return w;
  endfunction

  function automatic elem_t rnd_elem();
    logic [191:0] t;
    t = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
    return t[162:0];
  endfunction

  task automatic drive(bit v, bit tr, int wn, logic [31:0] a, logic [31:0] b,
                       logic [31:0] exp, string req, bit keep);
    item_t it;
    @(posedge clk); #1;
    call_valid = v; call_trace = tr; word_num = 3'(wn); opa = a; opb = b;
    it.exp = exp; it.req = req; it.wn = wn; it.keep = keep;
    q.push_back(it);
  endtask

  task automatic flush();
    @(posedge clk); #1;
    call_valid = 1'b0;
    @(negedge clk); #1;
  endtask

  task automatic do_idle(string req);
    drive(0, 0, 0, $urandom(), $urandom(), 32'h0, req, 0);
  endtask

  task automatic do_solve(int wn, logic [31:0] a, logic [31:0] b, string req, bit keep);
    logic [31:0] x;
    bit c;
    x = '0;
    if (wn <= 5) begin
      c = (wn == 0) ? 1'b0 : tb_c;
      for (int j = 31; j >= 0; j--) begin
        int i;
        i = 32 * wn + 31 - j;
        if (i < 162) begin
          c = c ^ a[j];
          x[j] = c;
        end
      end
      tb_c = (wn == 5) ? 1'b0 : c;
    end
    drive(1, 0, wn, a, b, x, req, keep);
  endtask

  task automatic do_trace(int wn, logic [31:0] a, logic [31:0] b, string req);
    bit p;
    logic [31:0] exp;
    exp = '0;
    if (wn <= 2) begin
      p = (wn == 0) ? 1'b0 : tb_c;
      for (int j = 0; j < 32; j++) begin
        if (32 * (2 * wn) + 31 - j < 163)     p = p ^ a[j];
        if (32 * (2 * wn + 1) + 31 - j < 163) p = p ^ b[j];
      end
      tb_c = p;
      exp[0] = p;
    end
    drive(1, 1, wn, a, b, exp, req, 1);
  endtask

  task automatic solve_elem(elem_t e, string req, int gap_after);
    elem_t x, xc, s;
    for (int k = 0; k < 6; k++) begin
      logic [31:0] a;
      a = word_of(e, k);
      if (k == 5) a = a | ($urandom() & 32'h1FFF_FFFF);
      do_solve(k, a, $urandom(), req, 1);
      if (k == gap_after) begin
        do_idle("R9");
        do_idle("R9");
        do_idle("R9");
      end
    end
    flush();
    for (int i = 0; i < 163; i++) x[i] = got[i / 32][31 - (i % 32)];
    s = {x[161:0], x[162]} ^ x;
    if (^e == 1'b0) begin
      check_el("R11", "X^2+X", s, e);
      xc = ~x;
      check_el("R11", "(X+1)^2+(X+1)", {xc[161:0], xc[162]} ^ xc, e);
    end else begin
      check_el("R11", "trace-one residue", s ^ e, elem_t'(1) << 162);
    end
  endtask

  task automatic trace_elem(elem_t e, string req);
    for (int k = 0; k < 3; k++) begin
      logic [31:0] b;
      b = word_of(e, 2 * k + 1);
      if (k == 2) b = b | ($urandom() & 32'h1FFF_FFFF);
      do_trace(k, word_of(e, 2 * k), b, req);
    end
    flush();
    check_el("R6", "final trace", elem_t'(got[2]), elem_t'(^e));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    elem_t e;
    rst_n = 1'b0; call_valid = 1'b0; call_trace = 1'b0;
    word_num = '0; opa = '0; opb = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    do_idle("R9");
    do_solve(1, 32'h8000_0001, $urandom(), "R10", 0);
    flush();

    solve_elem('0, "R1 R2", -1);
    solve_elem('1, "R1 R2", -1);
    solve_elem(elem_t'(1), "R1", -1);
    e = '0; e[162] = 1'b1; e[161] = 1'b1; e[160] = 1'b1;
    solve_elem(e, "R4", -1);
    e = '0;
    for (int i = 0; i < 163; i += 2) e[i] = 1'b1;
    solve_elem(e, "R1 R2", -1);
    for (int n = 0; n < 6; n++) begin
      e = rnd_elem();
      if (n < 4 && ^e) e[5] = ~e[5];
      solve_elem(e, "R1 R2 R5", -1);
    end
    solve_elem(rnd_elem(), "R9", 2);

    e = rnd_elem();
    do_solve(0, word_of(e, 0), 0, "R3", 0);
    do_solve(1, word_of(e, 1), 0, "R3", 0);
    do_solve(2, 32'hFFFF_FFFF, 0, "R3", 0);
    flush();
    solve_elem(rnd_elem(), "R3", -1);
    do_solve(0, 32'h0000_0001, 0, "R3", 0);
    trace_elem(rnd_elem(), "R3");

    do_solve(0, $urandom(), 0, "R8", 0);
    do_solve(6, $urandom(), $urandom(), "R8", 0);
    do_solve(7, $urandom(), $urandom(), "R8", 0);
    do_solve(1, $urandom(), 0, "R8", 0);
    do_trace(0, $urandom(), $urandom(), "R8");
    do_trace(3, $urandom(), $urandom(), "R8");
    do_trace(7, $urandom(), $urandom(), "R8");
    do_trace(1, $urandom(), $urandom(), "R8");
    flush();

    trace_elem('0, "R6");
    trace_elem('1, "R6 R7");
    trace_elem(elem_t'(1) << 162, "R6 R7");
    for (int n = 0; n < 4; n++) trace_elem(rnd_elem(), "R6 R7");

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule